// File: doc/BRIEF.md
# Clock Source and Divider Controller

This block chooses one base clock out of three candidate sources: the main oscillator halved, the PLL output, or a low-speed subclock. From that base clock it derives three divided clocks for the CPU, for the peripherals and for the external bus. Every clock is modelled as a one-cycle enable pulse on a single system clock, so the block is fully synchronous. Software owns a 2-bit source request, PLL and subclock enable bits, a bit that halts the main oscillator in subclock mode, and three 4-bit divider codes.

Source changes are limited to a fixed graph of permitted moves. A change into the PLL needs the PLL to be enabled and locked. A change into the subclock needs the subclock enable. Any request that breaks these rules leaves the selection as it was and sets a sticky error flag. Each divider picks up a new code only at the end of its current period. All three dividers restart together when the source changes.

Top module: `clk_src_ctrl`

## Requirements
- R1: Source codes: 00 and 01 give a base tick on every second main tick, 10 gives a base tick for each PLL tick, and 11 gives one for each subclock tick. `base_tick_o` is the registered base tick and appears one cycle after the source tick.
- R2: An accepted write is one of these moves: 00→01, 00→10, 01→00, 01→11, 10→00, 11→01. Any other differing request is rejected. A request equal to the current code has no effect and raises no error.
- R3: A move to 11 is rejected while `sub_en_i` is 0.
- R4: A move to 10 is rejected unless `pll_en_i` and `pll_lock_i` are both 1.
- R5: `main_run_o` is 0 exactly one cycle after a cycle with `main_halt_en_i`=1 and selection 11, and is 1 otherwise. A move 11→01 is rejected while `main_run_o` is 0.
- R6: A rejected write leaves `sel_o` unchanged and sets `err_o`. `err_o` stays set until `err_clr_i` is 1. If a rejection and a clear fall in the same cycle, the error stays set.
- R7: With divider code N, a divided tick is produced on every (N+1)-th base tick, in the same cycle as `base_tick_o` (0000 = no division, 1111 = divide by 16).
- R8: A divider code change takes effect only after the divided tick that ends the current period. After reset every divider runs its first period with code 0.
- R9: On an accepted source change, `base_tick_o` and all divided ticks are 0 in the following cycle. The dividers and the main-clock halving restart, and each divider loads its current code, so its first tick falls on the (N+1)-th base tick of the new source.
- R10: After reset, `sel_o`=00, `err_o`=0, `main_run_o`=1, `pll_run_o`=0, and all tick outputs are 0.
- R11: `pll_run_o` follows `pll_en_i` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick_i | input | 1 | Main oscillator tick |
| pll_tick_i | input | 1 | PLL output tick |
| sub_tick_i | input | 1 | Subclock tick |
| pll_lock_i | input | 1 | PLL lock indication |
| pll_en_i | input | 1 | PLL enable bit |
| sub_en_i | input | 1 | Subclock selection enable |
| main_halt_en_i | input | 1 | Allows the main oscillator to halt in subclock mode |
| sel_wr_i | input | 1 | Source-request write strobe |
| sel_req_i | input | 2 | Requested source code |
| err_clr_i | input | 1 | Clears the sticky error flag |
| cpu_div_i | input | 4 | CPU divider code |
| per_div_i | input | 4 | Peripheral divider code |
| ext_div_i | input | 4 | External bus divider code |
| sel_o | output | 2 | Current source code |
| err_o | output | 1 | Sticky rejected-request flag |
| main_run_o | output | 1 | Main oscillator run control |
| pll_run_o | output | 1 | PLL run control |
| base_tick_o | output | 1 | Base clock tick |
| cpu_tick_o | output | 1 | CPU clock tick |
| per_tick_o | output | 1 | Peripheral clock tick |
| ext_tick_o | output | 1 | External bus clock tick |

## Verification
The assertions assume that the selection moves only through the write strobe and that the source ticks, lock and enable inputs are sampled levels with no timing relation among them. The random stimulus drives every input at the falling edge. Write strobes are kept sparse, and divider codes change rarely, so that periods run to completion. Lock, enable and halt bits toggle often enough to reach both the accepting and the rejecting outcome of every move in the graph. Directed sequences add an illegal jump, a subclock request while it is disabled, a PLL request without lock, a blocked return from a halted subclock mode, and exact tick counts at codes 0, 1 and 15.

// File: rtl/clk_ctl_pkg.sv
package clk_ctl_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN_A = 2'b00,
        SRC_MAIN_B = 2'b01,
        SRC_PLL    = 2'b10,
        SRC_SUB    = 2'b11
    } src_e;

    // permitted source moves, independent of enable/lock conditions
    function automatic logic move_ok(src_e cur, src_e nxt);
        logic ok;
        case (cur)
            SRC_MAIN_A: ok = (nxt == SRC_MAIN_B) || (nxt == SRC_PLL);
            SRC_MAIN_B: ok = (nxt == SRC_SUB) || (nxt == SRC_MAIN_A);
            SRC_PLL:    ok = (nxt == SRC_MAIN_A);
            default:    ok = (nxt == SRC_MAIN_B);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/clk_src_sel.sv
module clk_src_sel
    import clk_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_tick_i,
    input  logic       pll_tick_i,
    input  logic       sub_tick_i,
    input  logic       pll_lock_i,
    input  logic       pll_en_i,
    input  logic       sub_en_i,
    input  logic       main_halt_en_i,
    input  logic       wr_i,
    input  logic [1:0] req_i,
    input  logic       err_clr_i,
    output logic [1:0] sel_o,
    output logic       switch_o,
    output logic       base_o,
    output logic       err_o,
    output logic       main_run_o,
    output logic       pll_run_o
);

    typedef struct packed {
        src_e sel;
        logic err;
        logic run;
        logic pll_run;
        logic phase;
    } sel_state_t;

    sel_state_t s_q, s_d;
    src_e       req;
    logic       differs, allowed, accept, reject;

    always_comb begin
        req     = src_e'(req_i);
        differs = wr_i && (req != s_q.sel);
        allowed = move_ok(s_q.sel, req);
        if (req == SRC_SUB && !sub_en_i)                    allowed = 1'b0;
        if (req == SRC_PLL && !(pll_en_i && pll_lock_i))    allowed = 1'b0;
        if (s_q.sel == SRC_SUB && !s_q.run)                 allowed = 1'b0;
        accept  = differs && allowed;
        reject  = differs && !allowed;

        case (s_q.sel)
            SRC_PLL: base_o = pll_tick_i;
            SRC_SUB: base_o = sub_tick_i;
            default: base_o = main_tick_i && s_q.phase;
        endcase

        s_d         = s_q;
        s_d.err     = reject || (s_q.err && !err_clr_i);
        s_d.run     = !(main_halt_en_i && s_q.sel == SRC_SUB);
        s_d.pll_run = pll_en_i;
        if (accept) begin
            s_d.sel   = req;
            s_d.phase = 1'b0;
        end else if (main_tick_i) begin
            s_d.phase = !s_q.phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sel: SRC_MAIN_A, err: 1'b0, run: 1'b1, pll_run: 1'b0, phase: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_o      = s_q.sel;
    assign switch_o   = accept;
    assign err_o      = s_q.err;
    assign main_run_o = s_q.run;
    assign pll_run_o  = s_q.pll_run;

endmodule

// File: rtl/clk_tick_div.sv
module clk_tick_div #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              base_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);

    typedef struct packed {
        logic [CODE_W-1:0] cnt;
        logic [CODE_W-1:0] div;
        logic              tick;
    } div_state_t;

    div_state_t d_q, d_d;

    always_comb begin
        d_d      = d_q;
        d_d.tick = 1'b0;
        if (restart_i) begin
            d_d.cnt = '0;
            d_d.div = code_i;
        end else if (base_i) begin
            if (d_q.cnt == d_q.div) begin
                d_d.cnt  = '0;
                d_d.div  = code_i;
                d_d.tick = 1'b1;
            end else begin
                d_d.cnt = d_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign tick_o = d_q.tick;

endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_tick_i,
    input  logic              pll_tick_i,
    input  logic              sub_tick_i,
    input  logic              pll_lock_i,
    input  logic              pll_en_i,
    input  logic              sub_en_i,
    input  logic              main_halt_en_i,
    input  logic              sel_wr_i,
    input  logic [1:0]        sel_req_i,
    input  logic              err_clr_i,
    input  logic [CODE_W-1:0] cpu_div_i,
    input  logic [CODE_W-1:0] per_div_i,
    input  logic [CODE_W-1:0] ext_div_i,
    output logic [1:0]        sel_o,
    output logic              err_o,
    output logic              main_run_o,
    output logic              pll_run_o,
    output logic              base_tick_o,
    output logic              cpu_tick_o,
    output logic              per_tick_o,
    output logic              ext_tick_o
);

    localparam int NUM_OUT = 3;

    logic                          switch_now;
    logic                          base_now;
    logic                          base_q;
    logic [NUM_OUT-1:0][CODE_W-1:0] codes;
    logic [NUM_OUT-1:0]            ticks;

    clk_src_sel u_sel (
        .clk            (clk),
        .rst_n          (rst_n),
        .main_tick_i    (main_tick_i),
        .pll_tick_i     (pll_tick_i),
        .sub_tick_i     (sub_tick_i),
        .pll_lock_i     (pll_lock_i),
        .pll_en_i       (pll_en_i),
        .sub_en_i       (sub_en_i),
        .main_halt_en_i (main_halt_en_i),
        .wr_i           (sel_wr_i),
        .req_i          (sel_req_i),
        .err_clr_i      (err_clr_i),
        .sel_o          (sel_o),
        .switch_o       (switch_now),
        .base_o         (base_now),
        .err_o          (err_o),
        .main_run_o     (main_run_o),
        .pll_run_o      (pll_run_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= 1'b0;
        end else begin
            base_q <= base_now && !switch_now;
        end
    end

    assign codes = {ext_div_i, per_div_i, cpu_div_i};

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
        clk_tick_div #(.CODE_W(CODE_W)) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (switch_now),
            .base_i    (base_now),
            .code_i    (codes[g]),
            .tick_o    (ticks[g])
        );
    end

    assign base_tick_o = base_q;
    assign cpu_tick_o  = ticks[0];
    assign per_tick_o  = ticks[1];
    assign ext_tick_o  = ticks[2];

endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pll_lock_i,
    input logic       pll_en_i,
    input logic       sub_en_i,
    input logic [1:0] sel_o,
    input logic       err_o,
    input logic       err_clr_i,
    input logic       main_run_o,
    input logic       base_tick_o,
    input logic       cpu_tick_o,
    input logic       per_tick_o,
    input logic       ext_tick_o
);

    // R2
    move_graph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o != $past(sel_o)) |->
            (($past(sel_o) == 2'b00 && (sel_o == 2'b01 || sel_o == 2'b10)) ||
             ($past(sel_o) == 2'b01 && (sel_o == 2'b11 || sel_o == 2'b00)) ||
             ($past(sel_o) == 2'b10 && sel_o == 2'b00) ||
             ($past(sel_o) == 2'b11 && sel_o == 2'b01)));

    // R3
    sub_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == 2'b11 && $past(sel_o) != 2'b11) |-> $past(sub_en_i));

    // R4
    pll_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == 2'b10 && $past(sel_o) != 2'b10) |-> $past(pll_en_i && pll_lock_i));

    // R5
    leave_sub_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_o) == 2'b11 && sel_o != 2'b11) |-> $past(main_run_o));

    // R5
    halt_only_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !main_run_o |-> ($past(sel_o) == 2'b11));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_o) && !$past(err_clr_i)) |-> err_o);

    // R7
    tick_on_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_tick_o || per_tick_o || ext_tick_o) |-> base_tick_o);

    // R9
    quiet_after_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o != $past(sel_o)) |->
            !(base_tick_o || cpu_tick_o || per_tick_o || ext_tick_o));

endmodule

bind clk_src_ctrl clk_src_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pll_lock_i  (pll_lock_i),
    .pll_en_i    (pll_en_i),
    .sub_en_i    (sub_en_i),
    .sel_o       (sel_o),
    .err_o       (err_o),
    .err_clr_i   (err_clr_i),
    .main_run_o  (main_run_o),
    .base_tick_o (base_tick_o),
    .cpu_tick_o  (cpu_tick_o),
    .per_tick_o  (per_tick_o),
    .ext_tick_o  (ext_tick_o)
);

// File: tb/clk_src_ctrl_tb.sv
module clk_src_ctrl_tb;

    localparam time CLK_P = 20ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_tick_i = 0, pll_tick_i = 0, sub_tick_i = 0, pll_lock_i = 0;
    logic pll_en_i = 0, sub_en_i = 0, main_halt_en_i = 0, sel_wr_i = 0, err_clr_i = 0;
    logic [1:0] sel_req_i = 0;
    logic [3:0] cpu_div_i = 0, per_div_i = 0, ext_div_i = 0;
    logic [1:0] sel_o;
    logic err_o, main_run_o, pll_run_o, base_tick_o, cpu_tick_o, per_tick_o, ext_tick_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    clk_src_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .main_tick_i(main_tick_i), .pll_tick_i(pll_tick_i),
        .sub_tick_i(sub_tick_i), .pll_lock_i(pll_lock_i), .pll_en_i(pll_en_i),
        .sub_en_i(sub_en_i), .main_halt_en_i(main_halt_en_i), .sel_wr_i(sel_wr_i),
        .sel_req_i(sel_req_i), .err_clr_i(err_clr_i), .cpu_div_i(cpu_div_i),
        .per_div_i(per_div_i), .ext_div_i(ext_div_i), .sel_o(sel_o), .err_o(err_o),
        .main_run_o(main_run_o), .pll_run_o(pll_run_o), .base_tick_o(base_tick_o),
        .cpu_tick_o(cpu_tick_o), .per_tick_o(per_tick_o), .ext_tick_o(ext_tick_o)
    );

    // ---------------- reference model built from the requirements ----------------
    logic [1:0] m_sel;
    logic m_err, m_run, m_pll, m_ph, m_base;
    logic [3:0] m_cnt [3];
    logic [3:0] m_div [3];
    logic       m_tick [3];

    function automatic bit graph_ok(logic [1:0] c, logic [1:0] n);
        return (c == 2'd0 && (n == 2'd1 || n == 2'd2)) || (c == 2'd1 && (n == 2'd3 || n == 2'd0)) ||
               (c == 2'd2 && n == 2'd0) || (c == 2'd3 && n == 2'd1);
    endfunction

    function automatic bit req_ok(logic [1:0] c, logic [1:0] n, bit sub_en, bit pll_en,
                                  bit lock, bit run);
        if (!graph_ok(c, n)) return 0;                // R2
        if (n == 2'd3 && !sub_en) return 0;           // R3
        if (n == 2'd2 && !(pll_en && lock)) return 0; // R4
        if (c == 2'd3 && !run) return 0;              // R5
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sel <= 0; m_err <= 0; m_run <= 1; m_pll <= 0; m_ph <= 0; m_base <= 0;
            for (int i = 0; i < 3; i++) begin m_cnt[i] <= 0; m_div[i] <= 0; m_tick[i] <= 0; end
        end else begin
            bit b, acc, rej;
            logic [3:0] code [3];
            code[0] = cpu_div_i; code[1] = per_div_i; code[2] = ext_div_i;
            b   = (m_sel == 2'd2) ? pll_tick_i : (m_sel == 2'd3) ? sub_tick_i : (main_tick_i && m_ph);
            acc = sel_wr_i && sel_req_i != m_sel &&
                  req_ok(m_sel, sel_req_i, sub_en_i, pll_en_i, pll_lock_i, m_run);
            rej = sel_wr_i && sel_req_i != m_sel && !acc;
            m_err  <= rej || (m_err && !err_clr_i);
            m_run  <= !(main_halt_en_i && m_sel == 2'd3);
            m_pll  <= pll_en_i;
            m_base <= b && !acc;
            if (acc) begin m_sel <= sel_req_i; m_ph <= 0; end
            else if (main_tick_i) m_ph <= !m_ph;
            for (int i = 0; i < 3; i++) begin
                m_tick[i] <= 0;
                if (acc) begin m_cnt[i] <= 0; m_div[i] <= code[i]; end
                else if (b) begin
                    if (m_cnt[i] == m_div[i]) begin
                        m_cnt[i] <= 0; m_div[i] <= code[i]; m_tick[i] <= 1;
                    end else m_cnt[i] <= m_cnt[i] + 1;
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: wait for falling edge, compare every output with the model
    task automatic cyc();
        @(negedge clk);
        chk(sel_o == m_sel, "R2 sel", sel_o, m_sel);
        chk(err_o == m_err, "R6 err", err_o, m_err);
        chk(main_run_o == m_run, "R5 main_run", main_run_o, m_run);
        chk(pll_run_o == m_pll, "R11 pll_run", pll_run_o, m_pll);
        chk(base_tick_o == m_base, "R1 base", base_tick_o, m_base);
        chk(cpu_tick_o == m_tick[0], "R7 cpu", cpu_tick_o, m_tick[0]);
        chk(per_tick_o == m_tick[1], "R8 per", per_tick_o, m_tick[1]);
        chk(ext_tick_o == m_tick[2], "R9 ext", ext_tick_o, m_tick[2]);
    endtask

    task automatic write_sel(logic [1:0] v);
        sel_wr_i = 1; sel_req_i = v;
        cyc();
        sel_wr_i = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cc, pc, ec;
        void'($urandom(32'h5EED_0C1C));
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        // R10 reset state
        chk(sel_o == 0 && !err_o && main_run_o && !pll_run_o, "R10 reset", sel_o, 0);
        chk(!(base_tick_o || cpu_tick_o || per_tick_o || ext_tick_o), "R10 ticks", 1, 0);

        // R2 illegal jump 00 -> 11 rejected, error raised
        sub_en_i = 1;
        write_sel(2'd3);
        chk(sel_o == 0, "R2 illegal kept", sel_o, 0);
        chk(err_o == 1, "R6 err set", err_o, 1);
        err_clr_i = 1; cyc(); err_clr_i = 0;
        chk(err_o == 0, "R6 err cleared", err_o, 0);
        // same code: no effect
        write_sel(2'd0);
        chk(err_o == 0, "R2 same code no error", err_o, 0);
        // R3 subclock disabled
        write_sel(2'd1);
        sub_en_i = 0;
        write_sel(2'd3);
        chk(sel_o == 1 && err_o, "R3 sub rejected", sel_o, 1);
        sub_en_i = 1; err_clr_i = 1;
        write_sel(2'd3);
        err_clr_i = 0;
        chk(sel_o == 3, "R3 sub accepted", sel_o, 3);
        chk(err_o == 0, "R6 cleared", err_o, 0);
        // R5 halted main blocks return
        main_halt_en_i = 1; cyc(); cyc();
        chk(main_run_o == 0, "R5 halted", main_run_o, 0);
        write_sel(2'd1);
        chk(sel_o == 3 && err_o, "R5 return blocked", sel_o, 3);
        main_halt_en_i = 0; err_clr_i = 1; cyc(); err_clr_i = 0;
        chk(main_run_o == 1, "R5 running", main_run_o, 1);
        write_sel(2'd1);
        chk(sel_o == 1, "R5 return ok", sel_o, 1);
        write_sel(2'd0);
        // R4 PLL without lock
        pll_en_i = 1; pll_lock_i = 0;
        write_sel(2'd2);
        chk(sel_o == 0 && err_o, "R4 no lock", sel_o, 0);
        // R7 R9 exact counts on PLL at codes 15, 0, 1
        pll_lock_i = 1; cpu_div_i = 15; per_div_i = 0; ext_div_i = 1; pll_tick_i = 1;
        write_sel(2'd2);
        chk(sel_o == 2, "R4 locked", sel_o, 2);
        chk(!base_tick_o && !per_tick_o, "R9 quiet switch", base_tick_o, 0);
        cc = 0; pc = 0; ec = 0;
        for (int k = 0; k < 48; k++) begin
            cpu_div_i = (k == 5) ? 4'd3 : 4'd15; // R8 mid-period change ignored
            if (k > 5) cpu_div_i = 4'd15;
            cyc();
            cc += cpu_tick_o; pc += per_tick_o; ec += ext_tick_o;
        end
        chk(cc == 3, "R7 div16 count", cc, 3);
        chk(pc == 48, "R7 div1 count", pc, 48);
        chk(ec == 24, "R7 div2 count", ec, 24);
        pll_tick_i = 0; err_clr_i = 1; cyc(); err_clr_i = 0;

        // constrained random phase
        for (int k = 0; k < 20000; k++) begin
            main_tick_i = ($urandom % 2) == 0;
            pll_tick_i  = ($urandom % 3) != 0;
            sub_tick_i  = ($urandom % 4) == 0;
            pll_lock_i  = ($urandom % 4) != 0;
            if ($urandom % 16 == 0) pll_en_i = !pll_en_i;
            if ($urandom % 16 == 0) sub_en_i = !sub_en_i;
            if ($urandom % 32 == 0) main_halt_en_i = !main_halt_en_i;
            sel_wr_i  = ($urandom % 8) == 0;
            sel_req_i = 2'($urandom);
            err_clr_i = ($urandom % 16) == 0;
            if ($urandom % 32 == 0) cpu_div_i = 4'($urandom);
            if ($urandom % 32 == 0) per_div_i = 4'($urandom);
            if ($urandom % 32 == 0) ext_div_i = 4'($urandom);
            cyc();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule